// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides whether a conditional jump is taken. A 5-bit condition field from the instruction is evaluated against the current zero, carry and negative flags. Each set bit of the field can independently veto the jump. If no set bit vetoes it, the jump is taken.

Two of the bits test the zero flag, one for each polarity. Two more test a second flag, again one for each polarity. The fifth bit chooses that second flag: carry or negative. Every one of the 32 codes therefore has a defined result. A code of all zeros always branches. A code that demands both polarities of the same flag never branches.

The decision is available combinationally on `take_now`. A registered copy, `take_q`, is captured when a valid strobe is asserted. It holds until the next strobe, so the decision can be pipelined with a fixed latency.

Top module: `branch_cond_eval`

## Requirements
- R1: With a condition code of 0 (no bits set), the jump is taken for every flag combination.
- R2: When condition bit 0 is set and the zero flag is 1, the jump is not taken.
- R3: When condition bit 1 is set and the zero flag is 0, the jump is not taken.
- R4: When condition bit 2 is set and the selected flag is 1, the jump is not taken.
- R5: When condition bit 3 is set and the selected flag is 0, the jump is not taken.
- R6: Condition bit 4 selects the flag tested by bits 2 and 3: 0 selects carry, 1 selects negative. The unselected flag has no effect on the result.
- R7: The jump is taken exactly when no set condition bit vetoes it. In particular, codes with bits 0 and 1 both set, or bits 2 and 3 both set, never branch.
- R8: `take_q` equals the `take_now` value present at a clock edge where `valid` is high. It is visible after that edge and holds while `valid` is low. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Strobe that captures the decision into `take_q` |
| cond | input | 5 | Condition field from the instruction |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| take_now | output | 1 | Combinational jump decision |
| take_q | output | 1 | Registered jump decision |

## Verification
`take_now` is due in the same cycle as its inputs. The bench drives inputs just after a rising edge and compares `take_now` at the falling edge of that cycle. `take_q` is due one edge after a strobed cycle. The bench's reference model holds a one-entry history: it updates that history with the model decision only when it drives `valid`, and compares `take_q` at every falling edge. All 256 combinations of code and flags are swept with the strobe, then random runs follow in which `valid` is often low, which exercises the hold behaviour.

// File: rtl/branch_cond_eval.sv
module branch_cond_eval #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [CW-1:0] cond,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_n,
  output logic          take_now,
  output logic          take_q
);

  logic sel_flag;
  logic [3:0] veto;

  assign sel_flag = cond[4] ? flag_n : flag_c;

  assign veto[0] = cond[0] &  flag_z;
  assign veto[1] = cond[1] & ~flag_z;
  assign veto[2] = cond[2] &  sel_flag;
  assign veto[3] = cond[3] & ~sel_flag;

  assign take_now = ~|veto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     take_q <= 1'b0;
    else if (valid) take_q <= take_now;
  end

  AST_ALWAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[3:0] == 4'b0) |-> take_now);                                    // R1
  AST_Z_SET_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[0] && flag_z) |-> !take_now);                                   // R2
  AST_Z_CLR_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[1] && !flag_z) |-> !take_now);                                  // R3
  AST_CN_SET_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[2] && (cond[4] ? flag_n : flag_c)) |-> !take_now);              // R4
  AST_CN_CLR_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[3] && !(cond[4] ? flag_n : flag_c)) |-> !take_now);             // R5
  AST_CONTRA: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond[0] && cond[1]) || (cond[2] && cond[3])) |-> !take_now);        // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (take_q == $past(take_now)));                               // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(take_q));                                          // R8

endmodule

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
  logic clk = 0, rst_n = 0, valid = 0;
  logic [4:0] cond = 0;
  logic flag_z = 0, flag_c = 0, flag_n = 0;
  logic take_now, take_q;
  int checks = 0, fails = 0;
  int exp_q = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  branch_cond_eval i_branch_cond_eval (.clk(clk), .rst_n(rst_n), .valid(valid),
    .cond(cond), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
    .take_now(take_now), .take_q(take_q));

  function automatic int model(int c, int z, int cf, int nf);
    int f;
    f = ((c / 16) % 2) ? nf : cf;
    if ((c % 2) && z) return 0;
    if (((c / 2) % 2) && !z) return 0;
    if (((c / 4) % 2) && f) return 0;
    if (((c / 8) % 2) && !f) return 0;
    return 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cond=%b z=%0d c=%0d n=%0d)",
               req, act, exp, cond, flag_z, flag_c, flag_n);
    end
  endtask

  function automatic string tag(int c, int z, int cf, int nf);
    int f;
    f = ((c / 16) % 2) ? nf : cf;
    if ((c % 4) == 3 || ((c / 4) % 4) == 3) return "R7";
    if ((c % 32) == 0 || (c % 16) == 0) return "R1";
    if ((c % 2) && z) return "R2";
    if (((c / 2) % 2) && !z) return "R3";
    if (((c / 4) % 2) && f) return "R4";
    if (((c / 8) % 2) && !f) return "R5";
    if ((c / 4) % 4 != 0) return "R6";
    return "R7";
  endfunction

  task automatic apply(int c, int z, int cf, int nf, bit v);
    int e;
    @(posedge clk); #1;
    cond = c[4:0]; flag_z = z[0]; flag_c = cf[0]; flag_n = nf[0]; valid = v;
    @(negedge clk);
    e = model(c, z, cf, nf);
    check(tag(c, z, cf, nf), int'(take_now), e);
    check("R8", int'(take_q), exp_q);
    if (v) exp_q = e;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8", int'(take_q), 0);
    rst_n = 1;
    for (int k = 0; k < 256; k++)
      apply(k % 32, (k / 32) % 2, (k / 64) % 2, (k / 128) % 2, 1'b1);
    for (int c = 0; c < 16; c++) begin
      apply(c, 0, 1, 0, 1'b1);
      apply(c, 0, 1, 1, 1'b1);
      apply(c + 16, 1, 0, 1, 1'b1);
      apply(c + 16, 1, 1, 1, 1'b1);
    end
    apply(0, 1, 1, 1, 1'b1);
    apply(3, 1, 1, 1, 1'b0);
    apply(3, 0, 0, 0, 1'b0);
    apply(12, 0, 0, 0, 1'b0);
    apply(3, 0, 0, 0, 1'b1);
    apply(0, 0, 0, 0, 1'b0);
    apply(0, 0, 0, 0, 1'b1);
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 31), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), ($urandom_range(0, 3) == 0));
    @(posedge clk); #1; valid = 0;
    @(negedge clk);
    check("R8", int'(take_q), exp_q);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule